// File: doc/BRIEF.md
# Constant-Ripple Hysteretic Gate Controller

This block switches the gate of a low-side buck transistor so that the inductor current ripples between a peak and a bottom level. Three digitised comparator flags drive it: peak reached, bottom reached and over-current. Each switching period has three parts. The gate rises. The flags are ignored for a fixed blanking window after the rise. The gate then falls when the peak flag is seen. An off-time follows, and when it ends the gate rises again.

The off-time is not fixed. A digital level register plays the part of a timing capacitor:

- During each on-time it is raised quickly, from the end of blanking until the bottom flag appears.
- During every other cycle of the switching period it is lowered slowly.
- A higher level gives a shorter off-time.

In steady state the bottom of the current lands on the bottom flag threshold.

An enable input gives external PWM dimming. While the enable is low the gate is held off and the level register is frozen. The first on-time after the enable rises adds nothing to the level. A fault input and a latched over-current stop switching. A synchronous clear restarts the block.

Top module: `hyst_gate_ctrl`

## Requirements
- R1: gate_o is low while rst_ni is low (asynchronously) and, with rst_ni high, is low in the cycle after any clock edge at which en_i is low.
- R2: After gate_o rises it stays high for at least LEB_CYC+1 cycles. peak_i, bottom_i and ocp_i are ignored at the first LEB_CYC clock edges after the rise.
- R3: After blanking, peak_i high at a clock edge turns gate_o off at that edge. With peak_i first high k cycles after blanking ends, the on-time is LEB_CYC+1+k cycles.
- R4: The off-time is max(TOFF_MIN, TOFF_MAX − (level >> MAP_SHIFT)) cycles. Here level is the register value at the edge where the gate turns off. When the off-time ends, gate_o rises without any further input.
- R5: At each post-blanking on-time edge before bottom_i is seen in that on-time, level rises by INC_STEP, saturating at 2^LVL_W−1. At every other edge of the switching period level falls by 1, saturating at 0. The default ratio is 100:1.
- R6: While en_i is low, level holds its value: it neither rises nor falls.
- R7: During the first on-time after en_i rises (or after start-up), level is not raised.
- R8: fault_i high at an edge turns gate_o off at that edge and clears level to 0. Switching restarts with a first on-time once fault_i is low.
- R9: ocp_i high after blanking turns gate_o off and latches the block off, with level cleared. The latch persists with en_i high until clr_i is pulsed.
- R10: clr_i high at an edge returns the block to idle with level 0 and the latch cleared. With en_i high the gate rises at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of state, level and latch |
| en_i | input | 1 | Dimming enable; low holds the gate off and freezes the level |
| fault_i | input | 1 | External fault; forces the gate off and clears the level |
| peak_i | input | 1 | Peak current comparator flag |
| bottom_i | input | 1 | Bottom current comparator flag |
| ocp_i | input | 1 | Over-current comparator flag |
| gate_o | output | 1 | Gate drive for the low-side switch |

## Verification
A corrupted level register cannot be seen until the next turn-off edge. It then appears as a wrong count of low cycles in the very next off-time, one switching period later at most. Faults in the blanking or sensing sequence show up in the on-time of the same period as a pulse that is too short or too long.

The expected off-times are worked out by hand from the level arithmetic. The chosen cases reach both the TOFF_MIN clamp and the saturated maximum level. The freeze case and the first-cycle case are set so that either mistake moves the off-time by several cycles.

// File: rtl/hyst_pkg.sv
package hyst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_SENSE = 2'd2,
    ST_OFF   = 2'd3
  } sw_state_e;
endpackage

// File: rtl/hyst_toff_map.sv
module hyst_toff_map #(
  parameter int LVL_W     = 14,
  parameter int MAP_SHIFT = 8,
  parameter int TOFF_MAX  = 64,
  parameter int TOFF_MIN  = 4,
  parameter int CNT_W     = 7
) (
  input  logic [LVL_W-1:0] level_i,
  output logic [CNT_W-1:0] toff_o
);
  localparam logic [LVL_W-1:0] SPAN = LVL_W'(TOFF_MAX - TOFF_MIN);

  logic [LVL_W-1:0] step;

  always_comb begin
    step = level_i >> MAP_SHIFT;
    if (step >= SPAN) toff_o = CNT_W'(TOFF_MIN);
    else              toff_o = CNT_W'(TOFF_MAX) - step[CNT_W-1:0];
  end
endmodule

// File: rtl/hyst_level_acc.sv
module hyst_level_acc #(
  parameter int LVL_W    = 14,
  parameter int INC_STEP = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             inc_i,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W:0]   STEP = (LVL_W+1)'(INC_STEP);
  localparam logic [LVL_W-1:0] TOP  = '1;

  logic [LVL_W:0] sum;
  assign sum = {1'b0, level_o} + STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           level_o <= '0;
    else if (clr_i)        level_o <= '0;
    else if (hold_i)       level_o <= level_o;
    else if (inc_i)        level_o <= sum[LVL_W] ? TOP : sum[LVL_W-1:0];
    else if (level_o != 0) level_o <= level_o - LVL_W'(1);
  end
endmodule

// File: rtl/hyst_seq.sv
module hyst_seq
  import hyst_pkg::*;
#(
  parameter int LEB_CYC = 4,
  parameter int CNT_W   = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             fault_i,
  input  logic             peak_i,
  input  logic             bottom_i,
  input  logic             ocp_i,
  input  logic [CNT_W-1:0] toff_i,
  output logic             gate_o,
  output logic             hold_o,
  output logic             inc_o,
  output logic             clr_lvl_o
);
  sw_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             first_q, bot_seen_q, ocp_lat_q;
  logic             run;

  assign run = en_i && !fault_i && !ocp_lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      first_q    <= 1'b0;
      bot_seen_q <= 1'b0;
      ocp_lat_q  <= 1'b0;
    end else if (clr_i) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      first_q    <= 1'b0;
      bot_seen_q <= 1'b0;
      ocp_lat_q  <= 1'b0;
    end else if (!run) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      bot_seen_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q    <= ST_BLANK;
          cnt_q      <= CNT_W'(LEB_CYC);
          first_q    <= 1'b1;
          bot_seen_q <= 1'b0;
        end
        ST_BLANK: begin
          if (cnt_q <= CNT_W'(1)) state_q <= ST_SENSE;
          cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_SENSE: begin
          if (ocp_i) begin
            ocp_lat_q <= 1'b1;
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
          end else begin
            if (bottom_i) bot_seen_q <= 1'b1;
            if (peak_i) begin
              state_q <= ST_OFF;
              cnt_q   <= toff_i;
              first_q <= 1'b0;
            end
          end
        end
        ST_OFF: begin
          if (cnt_q <= CNT_W'(1)) begin
            state_q    <= ST_BLANK;
            cnt_q      <= CNT_W'(LEB_CYC);
            bot_seen_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign gate_o    = (state_q == ST_BLANK) || (state_q == ST_SENSE);
  // frozen while disabled and on the restart edge
  assign hold_o    = !run || (state_q == ST_IDLE);
  assign inc_o     = (state_q == ST_SENSE) && !bottom_i && !bot_seen_q && !first_q;
  assign clr_lvl_o = clr_i || fault_i || ocp_lat_q;
endmodule

// File: rtl/hyst_gate_ctrl.sv
module hyst_gate_ctrl #(
  parameter int LEB_CYC   = 4,
  parameter int TOFF_MAX  = 64,
  parameter int TOFF_MIN  = 4,
  parameter int LVL_W     = 14,
  parameter int MAP_SHIFT = 8,
  parameter int INC_STEP  = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic fault_i,
  input  logic peak_i,
  input  logic bottom_i,
  input  logic ocp_i,
  output logic gate_o
);
  localparam int CNT_MAX = (LEB_CYC > TOFF_MAX) ? LEB_CYC : TOFF_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [LVL_W-1:0] level;
  logic [CNT_W-1:0] toff;
  logic             hold, inc, clr_lvl;

  hyst_toff_map #(
    .LVL_W(LVL_W), .MAP_SHIFT(MAP_SHIFT),
    .TOFF_MAX(TOFF_MAX), .TOFF_MIN(TOFF_MIN), .CNT_W(CNT_W)
  ) u_map (
    .level_i(level),
    .toff_o (toff)
  );

  hyst_level_acc #(.LVL_W(LVL_W), .INC_STEP(INC_STEP)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_lvl),
    .hold_i (hold),
    .inc_i  (inc),
    .level_o(level)
  );

  hyst_seq #(.LEB_CYC(LEB_CYC), .CNT_W(CNT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .en_i     (en_i),
    .fault_i  (fault_i),
    .peak_i   (peak_i),
    .bottom_i (bottom_i),
    .ocp_i    (ocp_i),
    .toff_i   (toff),
    .gate_o   (gate_o),
    .hold_o   (hold),
    .inc_o    (inc),
    .clr_lvl_o(clr_lvl)
  );
endmodule

// File: rtl/hyst_gate_chk.sv
module hyst_gate_chk #(
  parameter int LEB_CYC = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic clr_i,
  input logic en_i,
  input logic fault_i,
  input logic ocp_i,
  input logic gate_o
);
  localparam int HW = $clog2(LEB_CYC + 2);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   hi_cnt <= '0;
    else if (!gate_o)              hi_cnt <= '0;
    else if (hi_cnt < HW'(LEB_CYC)) hi_cnt <= hi_cnt + HW'(1);
  end

  // R1
  en_low_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_o);

  // R8
  fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !gate_o);

  // R2
  blank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && hi_cnt < HW'(LEB_CYC) && en_i && !fault_i && !clr_i) |=> gate_o);

  // R9
  ocp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && hi_cnt >= HW'(LEB_CYC) && ocp_i && !clr_i) |=> !gate_o);
endmodule

bind hyst_gate_ctrl hyst_gate_chk #(.LEB_CYC(LEB_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_i  (clr_i),
  .en_i   (en_i),
  .fault_i(fault_i),
  .ocp_i  (ocp_i),
  .gate_o (gate_o)
);

// File: tb/hyst_gate_ctrl_tb.sv
module hyst_gate_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEB        = 4;
  localparam int VEC_N      = 7;
  // charge cycles after blanking, expected off-time (LEB=4, INC=100, shift 8, max 64, min 4)
  localparam int K_T   [VEC_N] = '{5, 20, 20, 0, 60, 90, 0};
  localparam int OFF_T [VEC_N] = '{64, 57, 49, 49, 26, 4, 4};

  logic clk_i = 1'b0, rst_ni = 1'b0, clr_i = 1'b0, en_i = 1'b0, fault_i = 1'b0;
  logic peak_i = 1'b0, bottom_i = 1'b0, ocp_i = 1'b0;
  logic gate_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  hyst_gate_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .en_i(en_i), .fault_i(fault_i),
    .peak_i(peak_i), .bottom_i(bottom_i), .ocp_i(ocp_i), .gate_o(gate_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_hi(input int cap, output int n);
    n = 0;
    while (!gate_o && n < cap) begin n++; @(negedge clk_i); end
  endtask

  // entered at a negedge where gate_o was just seen high
  task automatic run_cyc(input int k, input bit pk_blank, input int ocp_h, input int cap,
                         output int on_n, output int off_n);
    int h;
    h = 1; on_n = 0; off_n = 0;
    while (gate_o && on_n < cap) begin
      on_n++;
      peak_i   = (pk_blank && h <= LEB) || (h == LEB + 1 + k);
      bottom_i = (h >= LEB + 1 + k);
      ocp_i    = (ocp_h != 0) && ((h == 2) || (h == ocp_h));
      @(negedge clk_i);
      h++;
    end
    peak_i = 1'b0; bottom_i = 1'b0; ocp_i = 1'b0;
    while (!gate_o && off_n < cap) begin off_n++; @(negedge clk_i); end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000 && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int on_n, off_n, w, lows;
    // R1 reset and disabled state
    repeat (3) @(negedge clk_i);
    chk("R1 gate in reset", int'(gate_o), 0);
    rst_ni = 1'b1;
    lows = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk_i); lows += int'(!gate_o); end
    chk("R1 gate with enable low", lows, 10);

    en_i = 1'b1;
    wait_hi(10, w);
    chk("R10 start after enable", w, 1);

    // R3 R4 R5 R7 table walk
    for (int v = 0; v < VEC_N; v++) begin
      run_cyc(K_T[v], 1'b0, 0, 200, on_n, off_n);
      chk("R3 on-time", on_n, LEB + 1 + K_T[v]);
      chk(v == 0 ? "R7 first off-time" : "R4 R5 off-time", off_n, OFF_T[v]);
    end

    // R8 fault forces off and clears level
    fault_i = 1'b1;
    @(negedge clk_i);
    chk("R8 gate off on fault", int'(gate_o), 0);
    repeat (3) @(negedge clk_i);
    fault_i = 1'b0;
    wait_hi(10, w);
    chk("R8 restart delay", w, 1);
    run_cyc(0, 1'b0, 0, 200, on_n, off_n);
    chk("R8 level cleared", off_n, 64);
    run_cyc(30, 1'b0, 0, 200, on_n, off_n);
    chk("R5 charge 30", off_n, 53);

    // R6 freeze while enable low, R7 no charge in first cycle
    en_i = 1'b0;
    lows = 0;
    for (int i = 0; i < 600; i++) begin @(negedge clk_i); lows += int'(!gate_o); end
    chk("R1 held off while disabled", lows, 600);
    en_i = 1'b1;
    wait_hi(10, w);
    run_cyc(10, 1'b0, 0, 200, on_n, off_n);
    chk("R6 R7 frozen level after enable", off_n, 53);

    // R2 R9 ocp in blanking ignored, after blanking latches
    run_cyc(10, 1'b0, 5, 100, on_n, off_n);
    chk("R2 ocp ignored in blanking", on_n, 5);
    chk("R9 latched off", off_n, 100);

    // R10 clear restarts
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    wait_hi(10, w);
    chk("R10 restart after clear", w, 1);
    run_cyc(0, 1'b0, 0, 200, on_n, off_n);
    chk("R10 level zero after clear", off_n, 64);

    // R2 peak during blanking ignored
    run_cyc(3, 1'b1, 0, 200, on_n, off_n);
    chk("R2 peak ignored in blanking", on_n, LEB + 4);

    // R1 asynchronous reset
    #1 rst_ni = 1'b0;
    #1 chk("R1 async reset", int'(gate_o), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule